// File: doc/BRIEF.md
# Multi-Image FPGA Configuration Loader

This controller lives in a small companion device next to a large FPGA and loads that FPGA's configuration from parallel flash. The flash is split into four equal sections, each able to hold one image. Coming out of reset, the loader takes the section number from a non-volatile default-section input and loads it. Later, the running design can ask for a different image: it places a 2-bit section number on the select pins and raises the reload strobe. A program-clear event, which wipes the FPGA's configuration, also starts a fresh load from the default section. A strap input turns every flash load off.

Before the FPGA is touched, the first two words of the chosen section are checked: a fixed sync word, then a word count. A runtime request for a bad section switches to the default section and raises the fallback flag. A bad default section raises the error flag and leaves the FPGA as it is. For a good section, the loader holds the FPGA's program line low for a fixed number of cycles, waits for init to go high, and streams exactly the stated number of words over a 32-bit valid/ready port. It then waits for done. While valid is high and ready is low, the word on the port must stay as it is. Ready may be low for any number of cycles. If init or done does not arrive in time, the error flag is raised. After a good load, the current-image outputs show the section number that was loaded.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset is released, with the inhibit strap low, the loader loads the section named by `boot_sel`. `cur_img` shows that section number once `cfg_done` has been seen.
- R2: If the `boot_sel` section is invalid when a power-up or program-clear load is attempted, `err` goes to 1 and `cfg_prog_n` is never driven low.
- R3: While `inhibit` is high, no load starts: `cfg_prog_n` stays high. This holds at reset, on a program-clear edge and on a reload edge.
- R4: A rising edge of `reload` while idle loads the section given by `img_sel`, with bit 0 as the low bit (`img_sel`=2'b10 selects section 2).
- R5: If the requested section is invalid, the `boot_sel` section is loaded instead and `fallback` goes to 1. If that section is also invalid, `err` goes to 1 as well and `cfg_prog_n` is not pulsed.
- R6: Section s starts at flash word s*2^SEC_AW. The section is valid only when word 0 equals 32'hC0DEF00D and word 1 holds a count from 1 to 2^SEC_AW-2.
- R7: A valid section sends exactly its count of words, read from word 2 upward in address order, over `cfg_data`/`cfg_valid`/`cfg_ready`. While `cfg_valid` is 1 and `cfg_ready` is 0, `cfg_valid` stays 1 and `cfg_data` does not change.
- R8: A load drives `cfg_prog_n` low for exactly PROG_CYC cycles and sends no data until `cfg_init` is high. `cur_img` changes only after `cfg_done` has been seen high.
- R9: If `cfg_init` or `cfg_done` is not seen within TMO_CYC cycles of the wait starting, `err` goes to 1 and `cur_img` keeps its old value.
- R10: Reload edges and program-clear edges that arrive while a load is in progress are ignored.
- R11: A rising edge of `prog_clear` while idle starts a load of the `boot_sel` section.
- R12: `err` and `fallback` are cleared when a new load attempt starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; power-up load follows release |
| inhibit | input | 1 | Strap; high blocks every flash load |
| boot_sel | input | 2 | Default section, from non-volatile storage |
| prog_clear | input | 1 | FPGA configuration cleared; rising edge requests reload from the default |
| reload | input | 1 | Runtime reload request; rising edge is the trigger |
| img_sel | input | 2 | Requested section, bit 0 low |
| fl_rd | output | 1 | Flash read strobe |
| fl_addr | output | SEC_AW+2 | Flash word address |
| fl_data | input | 32 | Flash word, valid one cycle after `fl_rd` |
| cfg_prog_n | output | 1 | FPGA program line, active low |
| cfg_init | input | 1 | FPGA ready to accept configuration |
| cfg_done | input | 1 | FPGA configuration complete |
| cfg_data | output | 32 | Configuration word |
| cfg_valid | output | 1 | `cfg_data` holds a word |
| cfg_ready | input | 1 | FPGA accepts the word this cycle |
| err | output | 1 | Error indicator |
| fallback | output | 1 | Default section used in place of the requested one |
| cur_img | output | 2 | Section of the last successful load |

## Verification
The bench targets the decision between fallback and error. One case is a bad request with a good default, which must load the default and set only `fallback`. The other is a bad request with a bad default, which must not pulse the program line at all. A loader that mixed these up would either reconfigure the FPGA from garbage or leave a good default unused. Sections with a wrong sync word and with a zero count are both used, so a check that looked at only one header word would load a blank image. Every load runs under random back-pressure, and each word is compared against its address. A design that advanced on a stalled word would drop words or send them twice. The remaining cases are a second request arriving mid-load, an init that never rises, a done that never rises, and reset with a bad default. A design that got these wrong would restart mid-stream, hang, or report a section it never finished.

// File: rtl/cil_pkg.sv
package cil_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR0,
    ST_HDR1,
    ST_HDR2,
    ST_PROG,
    ST_WINIT,
    ST_STREAM,
    ST_WDONE
  } cil_state_t;

  localparam logic [31:0] CIL_SYNC = 32'hC0DEF00D;
endpackage

// File: rtl/cil_edge.sv
module cil_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= sig;
  end

  assign rise = sig & ~prev;
endmodule

// File: rtl/cil_timer.sv
module cil_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (cnt != '1)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cil_stream.sv
module cil_stream #(
  parameter int SEC_AW = 6,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [1:0]        sect,
  input  logic [SEC_AW-1:0] len,
  output logic              rd,
  output logic [SEC_AW+1:0] addr,
  input  logic [DW-1:0]     rdata,
  output logic [DW-1:0]     data,
  output logic              valid,
  input  logic              ready,
  output logic              done
);
  logic [SEC_AW-1:0] left;
  logic [SEC_AW-1:0] idx;
  logic              pend;

  // a read is issued only when the output slot will be free on its return
  assign rd   = run && (left != '0) && !pend && (!valid || ready);
  assign addr = {sect, idx};
  assign done = run && (left == '0) && !pend && !valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left  <= '0;
      idx   <= '0;
      pend  <= 1'b0;
      valid <= 1'b0;
      data  <= '0;
    end else if (start) begin
      left  <= len;
      idx   <= SEC_AW'(2);
      pend  <= 1'b0;
      valid <= 1'b0;
    end else begin
      pend <= rd;
      if (rd) begin
        left <= left - 1'b1;
        idx  <= idx + 1'b1;
      end
      if (pend) begin
        data  <= rdata;
        valid <= 1'b1;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cil_pkg::*;
#(
  parameter int          SEC_AW    = 6,
  parameter int          DW        = 32,
  parameter int          PROG_CYC  = 4,
  parameter int          TMO_CYC   = 4096,
  parameter logic [31:0] SYNC_WORD = CIL_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibit,
  input  logic [1:0]        boot_sel,
  input  logic              prog_clear,
  input  logic              reload,
  input  logic [1:0]        img_sel,
  output logic              fl_rd,
  output logic [SEC_AW+1:0] fl_addr,
  input  logic [DW-1:0]     fl_data,
  output logic              cfg_prog_n,
  input  logic              cfg_init,
  input  logic              cfg_done,
  output logic [DW-1:0]     cfg_data,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic              err,
  output logic              fallback,
  output logic [1:0]        cur_img
);
  localparam int TMAX    = (TMO_CYC > PROG_CYC) ? TMO_CYC : PROG_CYC;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int MAX_LEN = (1 << SEC_AW) - 2;
  localparam logic [TW-1:0] PROG_LAST = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);

  cil_state_t        state, state_n;
  logic [1:0]        rise;
  logic [TW-1:0]     tcnt;
  logic [1:0]        sect;
  logic              is_req, boot_pend, sync_ok;
  logic [SEC_AW-1:0] len_q;
  logic              hdr_ok, go, s_rd, s_done, s_start;
  logic [SEC_AW+1:0] s_addr;

  cil_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig({prog_clear, reload}), .rise(rise)
  );

  cil_timer #(.CW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(state_n != state), .cnt(tcnt)
  );

  assign s_start = (state == ST_WINIT) && cfg_init;

  cil_stream #(.SEC_AW(SEC_AW), .DW(DW)) u_strm (
    .clk(clk), .rst_n(rst_n), .start(s_start), .run(state == ST_STREAM),
    .sect(sect), .len(len_q), .rd(s_rd), .addr(s_addr), .rdata(fl_data),
    .data(cfg_data), .valid(cfg_valid), .ready(cfg_ready), .done(s_done)
  );

  assign go     = !inhibit && (boot_pend || rise[1] || rise[0]);
  assign hdr_ok = sync_ok && (fl_data != '0) && (fl_data <= DW'(MAX_LEN));

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:   if (go) state_n = ST_HDR0;
      ST_HDR0:   state_n = ST_HDR1;
      ST_HDR1:   state_n = ST_HDR2;
      ST_HDR2:   state_n = hdr_ok ? ST_PROG : (is_req ? ST_HDR0 : ST_IDLE);
      ST_PROG:   if (tcnt == PROG_LAST) state_n = ST_WINIT;
      ST_WINIT:  if (cfg_init) state_n = ST_STREAM;
                 else if (tcnt == TMO_LAST) state_n = ST_IDLE;
      ST_STREAM: if (s_done) state_n = ST_WDONE;
      ST_WDONE:  if (cfg_done || tcnt == TMO_LAST) state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sect      <= 2'd0;
      is_req    <= 1'b0;
      boot_pend <= 1'b1;
      sync_ok   <= 1'b0;
      len_q     <= '0;
      err       <= 1'b0;
      fallback  <= 1'b0;
      cur_img   <= 2'd0;
    end else begin
      state <= state_n;
      unique case (state)
        ST_IDLE: begin
          if (inhibit) begin
            boot_pend <= 1'b0;
          end else if (go) begin
            boot_pend <= 1'b0;
            err       <= 1'b0;
            fallback  <= 1'b0;
            if (boot_pend || rise[1]) begin
              sect   <= boot_sel;
              is_req <= 1'b0;
            end else begin
              sect   <= img_sel;
              is_req <= 1'b1;
            end
          end
        end
        ST_HDR1: sync_ok <= (fl_data == SYNC_WORD);
        ST_HDR2: begin
          if (hdr_ok) begin
            len_q <= fl_data[SEC_AW-1:0];
          end else if (is_req) begin
            sect     <= boot_sel;
            is_req   <= 1'b0;
            fallback <= 1'b1;
          end else begin
            err <= 1'b1;
          end
        end
        ST_WINIT: if (!cfg_init && tcnt == TMO_LAST) err <= 1'b1;
        ST_WDONE: begin
          if (cfg_done)              cur_img <= sect;
          else if (tcnt == TMO_LAST) err     <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cfg_prog_n = (state != ST_PROG);
  assign fl_rd      = (state == ST_HDR0) || (state == ST_HDR1) || s_rd;
  always_comb begin
    if (state == ST_HDR0)      fl_addr = {sect, {SEC_AW{1'b0}}};
    else if (state == ST_HDR1) fl_addr = {sect, SEC_AW'(1)};
    else                       fl_addr = s_addr;
  end
endmodule

// File: rtl/cil_chk.sv
module cil_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_valid,
  input logic          cfg_ready,
  input logic [DW-1:0] cfg_data,
  input logic          cfg_prog_n,
  input logic          fl_rd,
  input logic          cfg_done,
  input logic [1:0]    cur_img,
  input logic          err,
  input logic          fallback
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_data)); // R7

  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> !cfg_valid && !fl_rd); // R8

  AST_IMG_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_img) |-> $past(cfg_done)); // R8

  AST_FALLBACK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fallback) |-> !err); // R5

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !cfg_valid); // R9
endmodule

bind cfg_image_loader cil_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cfg_data(cfg_data), .cfg_prog_n(cfg_prog_n), .fl_rd(fl_rd),
  .cfg_done(cfg_done), .cur_img(cur_img), .err(err), .fallback(fallback)
);

// File: tb/sim_cfg_image_loader.sv
module sim_cfg_image_loader;
  localparam int SEC_AW = 6;
  localparam int PROG_CYC = 4;
  localparam int TMO_CYC = 100;
  localparam int WAITC = 400;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, inhibit, prog_clear, reload;
  logic [1:0] boot_sel, img_sel;
  logic fl_rd;
  logic [SEC_AW+1:0] fl_addr;
  logic [31:0] fl_data = '0;
  logic cfg_prog_n, cfg_valid, err, fallback;
  logic [31:0] cfg_data;
  logic [1:0] cur_img;
  logic cfg_init = 1'b0, cfg_done = 1'b0, cfg_ready = 1'b0;

  cfg_image_loader #(.SEC_AW(SEC_AW), .PROG_CYC(PROG_CYC), .TMO_CYC(TMO_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .boot_sel(boot_sel),
    .prog_clear(prog_clear), .reload(reload), .img_sel(img_sel),
    .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_data(fl_data),
    .cfg_prog_n(cfg_prog_n), .cfg_init(cfg_init), .cfg_done(cfg_done),
    .cfg_data(cfg_data), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .err(err), .fallback(fallback), .cur_img(cur_img)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  function automatic logic [31:0] wordv(int s, int i);
    return 32'h5A00_0000 | (s << 12) | i;
  endfunction
  function automatic int len_of(int s);
    return (s == 0) ? 5 : (s == 2) ? 8 : 0;
  endfunction

  // flash model: 4 sections of 64 words, one-cycle read latency
  logic [31:0] mem [256];
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = wordv(i >> SEC_AW, i % 64);
    mem[0]   = 32'hC0DEF00D; mem[1]   = 32'd5;
    mem[64]  = ~32'hC0DEF00D; mem[65] = 32'd4;
    mem[128] = 32'hC0DEF00D; mem[129] = 32'd8;
    mem[192] = 32'hC0DEF00D; mem[193] = 32'd0;
  end
  always @(posedge clk) if (fl_rd) fl_data <= mem[fl_addr];

  // FPGA model
  int exp_sec = 0, exp_len = 0, rx_cnt = 0, rx_bad = 0;
  int icnt = 0, prog_cnt = 0, low_len = 0, low_run = 0;
  bit init_block = 0, done_block = 0, prog_d = 1;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cfg_ready <= lfsr[0] | lfsr[3];
    prog_d <= cfg_prog_n;
    if (prog_d && !cfg_prog_n) prog_cnt <= prog_cnt + 1;
    if (!cfg_prog_n) low_run <= low_run + 1;
    else if (!prog_d) begin low_len <= low_run; low_run <= 0; end
    if (!cfg_prog_n) begin
      cfg_init <= 1'b0; icnt <= 0; cfg_done <= 1'b0; rx_cnt <= 0; rx_bad <= 0;
    end else begin
      if (!init_block && icnt < 3) icnt <= icnt + 1;
      cfg_init <= (icnt == 3) && !init_block;
      if (cfg_valid && cfg_ready) begin
        if (cfg_data != wordv(exp_sec, rx_cnt + 2)) rx_bad <= rx_bad + 1;
        rx_cnt <= rx_cnt + 1;
      end
      if (rx_cnt == exp_len && exp_len != 0 && !done_block) cfg_done <= 1'b1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_reload(logic [1:0] s);
    @(negedge clk); img_sel = s; reload = 1'b1;
    @(negedge clk); reload = 1'b0;
  endtask
  task automatic pulse_prog();
    @(negedge clk); prog_clear = 1'b1;
    @(negedge clk); prog_clear = 1'b0;
  endtask
  task automatic settle();
    repeat (WAITC) @(posedge clk);
    @(negedge clk);
  endtask

  // {req[1:0], boot[1:0], img[1:0], fallback, err}
  localparam logic [7:0] VEC [6] = '{
    {2'd2, 2'd0, 2'd2, 1'b0, 1'b0},
    {2'd0, 2'd0, 2'd0, 1'b0, 1'b0},
    {2'd1, 2'd2, 2'd2, 1'b1, 1'b0},
    {2'd3, 2'd0, 2'd0, 1'b1, 1'b0},
    {2'd1, 2'd3, 2'd0, 1'b1, 1'b1},
    {2'd2, 2'd3, 2'd2, 1'b0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 0; inhibit = 1; boot_sel = 0; prog_clear = 0; reload = 0; img_sel = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R3 reset prog_n", cfg_prog_n, 1);
    chk("R3 reset err", err, 0);
    chk("R3 reset fallback", fallback, 0);
    chk("R3 reset cur_img", cur_img, 0);
    chk("R3 reset valid", cfg_valid, 0);
    p0 = prog_cnt;
    repeat (50) @(posedge clk); @(negedge clk);
    chk("R3 inhibit power-up", prog_cnt - p0, 0);
    pulse_reload(2); settle();
    chk("R3 inhibit reload", prog_cnt - p0, 0);
    pulse_prog(); settle();
    chk("R3 inhibit prog_clear", prog_cnt - p0, 0);

    inhibit = 0; boot_sel = 2; exp_sec = 2; exp_len = 8;
    pulse_prog(); settle();
    chk("R11 prog_clear load img", cur_img, 2);
    chk("R11 prog_clear err", err, 0);
    chk("R7 word count", rx_cnt, 8);
    chk("R7 word order", rx_bad, 0);
    chk("R8 program pulse width", low_len, PROG_CYC);

    for (int k = 0; k < 6; k++) begin
      logic [7:0] v;
      v = VEC[k];
      boot_sel = v[5:4];
      if (!v[0]) begin exp_sec = v[3:2]; exp_len = len_of(v[3:2]); end
      p0 = prog_cnt;
      pulse_reload(v[7:6]); settle();
      chk("R4 R6 table cur_img", cur_img, v[3:2]);
      chk("R5 table fallback", fallback, v[1]);
      chk("R5 R12 table err", err, v[0]);
      chk("R5 table program pulses", prog_cnt - p0, v[0] ? 0 : 1);
      if (!v[0]) begin
        chk("R7 table word count", rx_cnt, exp_len);
        chk("R7 table word order", rx_bad, 0);
      end
    end

    boot_sel = 0; exp_sec = 0; exp_len = 5; p0 = prog_cnt;
    pulse_reload(0);
    repeat (6) @(posedge clk);
    pulse_reload(2);
    pulse_prog();
    settle();
    chk("R10 busy ignore img", cur_img, 0);
    chk("R10 busy ignore pulses", prog_cnt - p0, 1);
    chk("R10 busy words", rx_bad, 0);

    init_block = 1; exp_sec = 2; exp_len = 8;
    pulse_reload(2); settle();
    chk("R9 init timeout err", err, 1);
    chk("R9 init timeout cur_img", cur_img, 0);
    init_block = 0;

    done_block = 1;
    pulse_reload(2); settle();
    chk("R9 done timeout err", err, 1);
    chk("R8 no done keeps cur_img", cur_img, 0);
    chk("R7 words before done", rx_cnt, 8);
    done_block = 0;

    @(negedge clk); rst_n = 0; boot_sel = 1;
    repeat (5) @(posedge clk);
    p0 = prog_cnt;
    @(negedge clk); rst_n = 1;
    settle();
    chk("R2 bad default err", err, 1);
    chk("R2 bad default no pulse", prog_cnt - p0, 0);
    chk("R2 bad default cur_img", cur_img, 0);

    @(negedge clk); rst_n = 0; boot_sel = 2; exp_sec = 2; exp_len = 8;
    repeat (5) @(posedge clk);
    p0 = prog_cnt;
    @(negedge clk); rst_n = 1;
    settle();
    chk("R1 power-up cur_img", cur_img, 2);
    chk("R1 power-up err", err, 0);
    chk("R1 power-up pulses", prog_cnt - p0, 1);
    chk("R1 power-up words", rx_cnt, 8);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule